// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the word address for a four-beat burst into a memory array. When an access is accepted, the block captures a start address from the external address bus. A two-bit beat counter then supplies the addresses for the remaining beats. The counter advances only on cycles where the advance input is high.

The burst order is chosen when the burst is loaded. The first order is linear: the low address bits count up from the start value and wrap within the four-word group. The second order is interleaved: the low bits are the start value XORed with the beat number, which is the fill order some processor caches expect. Only the two least significant address bits change during a burst. The upper bits keep the loaded value until the next load.

The output is combinational from the captured registers, so a loaded address appears on the output one clock edge after the load strobe. The memory array and the bus control logic that decides when to load or advance are outside this block.

Top module: `burst_addr_seq`

## Requirements
- R1: After reset is asserted (rst_n low), addr_o reads all zeros and the order is linear.
- R2: On a clock edge with load_i high, addr_o equals the addr_i sampled at that edge from the following cycle onward, and the beat count restarts at 0.
- R3: With linear order (mode_i = 0 at load), addr_o[1:0] equals (start[1:0] + beats) mod 4, where beats is the number of advance edges since the load.
- R4: With interleaved order (mode_i = 1 at load), addr_o[1:0] equals start[1:0] XOR beats, bit by bit.
- R5: On an edge with load_i low and adv_i low, addr_o does not change.
- R6: When load_i and adv_i are both high on the same edge, the load wins: addr_o becomes addr_i and the beat count is 0.
- R7: addr_o bits above bit 1 stay equal to the loaded start value for the whole burst, including when the low bits wrap from 3 to 0.
- R8: After four advances without a load, addr_o returns to the start address in either order.
- R9: mode_i is sampled only on a load edge; changing it in the middle of a burst has no effect on addr_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Accepted access: capture addr_i and mode_i, clear the beat count |
| adv_i | input | 1 | Advance to the next beat of the burst |
| mode_i | input | 1 | Burst order at load time: 0 linear, 1 interleaved |
| addr_i | input | ADDR_W | External start address |
| addr_o | output | ADDR_W | Current array word address |

## Verification
The bench targets start values with both low bits set, where a linear design that carries into bit 2 would corrupt the upper address. It also runs full four-beat bursts in both orders, where a counter that fails to wrap never returns to the start word. It drives load and advance together; if advance had priority, the output would move one beat past the new start. It toggles mode in the middle of a burst, where a design that reads mode_i on every cycle would jump between the two orders. Random load, advance and mode patterns check the hold behaviour and both order functions against a reference model computed in the bench.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  localparam int BEAT_W = 2;
  typedef logic [BEAT_W-1:0] beat_t;

  typedef enum logic {
    ORD_LINEAR = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } burst_order_e;

  // Linear: count up from the start word and wrap within the group.
  function automatic beat_t seq_linear(beat_t start, beat_t beat);
    return beat_t'(start + beat);
  endfunction

  // Interleaved: flip start bits wherever the beat number has a one.
  function automatic beat_t seq_interleave(beat_t start, beat_t beat);
    return start ^ beat;
  endfunction
endpackage

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
  import burst_seq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  clr_i,
  input  logic  step_i,
  output beat_t beat_o
);
  beat_t beat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) beat_q <= '0;
    else if (clr_i) beat_q <= '0;
    else if (step_i) beat_q <= beat_t'(beat_q + 1'b1);
  end

  assign beat_o = beat_q;
endmodule

// File: rtl/burst_start_reg.sv
module burst_start_reg
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              mode_i,
  output logic [ADDR_W-1:0] start_o,
  output burst_order_e      order_o
);
  logic [ADDR_W-1:0] start_q;
  burst_order_e      order_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      order_q <= ORD_LINEAR;
    end else if (cap_i) begin
      start_q <= addr_i;
      order_q <= burst_order_e'(mode_i);
    end
  end

  assign start_o = start_q;
  assign order_o = order_q;
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
  import burst_seq_pkg::*;
(
  input  burst_order_e order_i,
  input  beat_t        start_i,
  input  beat_t        beat_i,
  output beat_t        low_o
);
  always_comb begin
    unique case (order_i)
      ORD_INTERLEAVE: low_o = seq_interleave(start_i, beat_i);
      default:        low_o = seq_linear(start_i, beat_i);
    endcase
  end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              adv_i,
  input  logic              mode_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int UPPER_W = ADDR_W - BEAT_W;

  // Named internal events for the checker.
  logic              cap_w;
  logic              step_w;
  beat_t             beat_w;
  beat_t             low_w;
  burst_order_e      order_w;
  logic [ADDR_W-1:0] start_w;

  assign cap_w  = load_i;
  assign step_w = adv_i & ~load_i;

  burst_beat_ctr u_ctr (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (cap_w),
    .step_i (step_w),
    .beat_o (beat_w)
  );

  burst_start_reg #(.ADDR_W(ADDR_W)) u_start (
    .clk     (clk),
    .rst_n   (rst_n),
    .cap_i   (cap_w),
    .addr_i  (addr_i),
    .mode_i  (mode_i),
    .start_o (start_w),
    .order_o (order_w)
  );

  burst_order_map u_map (
    .order_i (order_w),
    .start_i (start_w[BEAT_W-1:0]),
    .beat_i  (beat_w),
    .low_o   (low_w)
  );

  assign addr_o = {start_w[ADDR_W-1 -: UPPER_W], low_w};
endmodule

// File: rtl/burst_addr_seq_checker.sv
module burst_addr_seq_checker
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input logic              clk,
  input logic              rst_n,
  input logic              load_i,
  input logic              adv_i,
  input logic              mode_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [ADDR_W-1:0] addr_o,
  input beat_t             beat_w,
  input burst_order_e      order_w,
  input logic [ADDR_W-1:0] start_w
);
  p_load_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (addr_o == $past(addr_i)) && (beat_w == '0));

  p_load_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && adv_i) |=> (beat_w == '0) && (addr_o == $past(addr_i)));

  p_hold_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !adv_i) |=> $stable(addr_o));

  p_advance_moves_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && adv_i) |=> (addr_o[BEAT_W-1:0] != $past(addr_o[BEAT_W-1:0])));

  p_upper_fixed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> (addr_o[ADDR_W-1:BEAT_W] == $past(addr_o[ADDR_W-1:BEAT_W])));

  p_origin_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_w == '0) |-> (addr_o == start_w));

  p_mode_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(order_w));
endmodule

bind burst_addr_seq burst_addr_seq_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .load_i  (load_i),
  .adv_i   (adv_i),
  .mode_i  (mode_i),
  .addr_i  (addr_i),
  .addr_o  (addr_o),
  .beat_w  (beat_w),
  .order_w (order_w),
  .start_w (start_w)
);

// File: tb/burst_addr_seq_test.sv
module burst_addr_seq_test;
  localparam int AW = 17;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          load_i = 1'b0;
  logic          adv_i = 1'b0;
  logic          mode_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [AW-1:0] addr_o;

  int n_checks = 0;
  int n_fail = 0;

  logic [AW-1:0] m_start = '0;
  int            m_beats = 0;
  logic          m_ilv = 1'b0;

  always #2.5 clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW)) uut (.*);

  // Reference: linear by integer sum mod 4, interleave bit by bit.
  function automatic logic [AW-1:0] model_addr(logic [AW-1:0] s, int beats, logic ilv);
    int b = beats % 4;
    int lo;
    logic [AW-1:0] r;
    if (ilv) begin
      lo = 0;
      if (s[0] != b[0]) lo += 1;
      if (s[1] != b[1]) lo += 2;
    end else begin
      lo = int'(s[1:0]) + b;
      if (lo >= 4) lo -= 4;
    end
    r = s;
    r[1:0] = lo[1:0];
    return r;
  endfunction

  task automatic check(string req, logic [AW-1:0] act, logic [AW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: addr_o=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive at negedge, let the edge pass, update the model, check.
  task automatic step(logic ld, logic av, logic md, logic [AW-1:0] a, string req);
    @(negedge clk);
    load_i = ld; adv_i = av; mode_i = md; addr_i = a;
    @(posedge clk);
    if (ld) begin
      m_start = a; m_beats = 0; m_ilv = md;
    end else if (av) begin
      m_beats++;
    end
    #1;
    check(req, addr_o, model_addr(m_start, m_beats, m_ilv));
  endtask

  initial begin
    #200000;
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [AW-1:0] s;
    void'($urandom(32'd1234));
    #12;
    check("R1", addr_o, '0);
    @(negedge clk); rst_n = 1'b1;

    // R3 full linear burst from low bits 3; R7 no carry; R8 wrap.
    s = 17'h0_1237;
    step(1'b1, 1'b0, 1'b0, s, "R2");
    for (int k = 0; k < 4; k++) step(1'b0, 1'b1, 1'b0, '0, "R3");
    check("R8", addr_o, s);
    step(1'b0, 1'b1, 1'b0, '0, "R7");
    check("R7", {addr_o[AW-1:2], 2'b00}, {s[AW-1:2], 2'b00});

    // R4 interleaved burst; R9 mode flips mid burst ignored.
    s = 17'h1_ABC6;
    step(1'b1, 1'b0, 1'b1, s, "R2");
    step(1'b0, 1'b1, 1'b0, '0, "R9");
    step(1'b0, 1'b1, 1'b1, '0, "R4");
    step(1'b0, 1'b1, 1'b0, '0, "R9");
    step(1'b0, 1'b1, 1'b0, '0, "R4");
    check("R8", addr_o, s);

    // R5 hold with inputs wiggling.
    step(1'b0, 1'b1, 1'b0, '0, "R4");
    step(1'b0, 1'b0, 1'b1, 17'h1_FFFF, "R5");
    step(1'b0, 1'b0, 1'b0, 17'h0_5555, "R5");

    // R6 load and advance together.
    s = 17'h0_0F01;
    step(1'b1, 1'b1, 1'b0, s, "R6");
    check("R6", addr_o, s);

    // Random mix.
    for (int i = 0; i < 3000; i++) begin
      logic ld, av, md;
      logic [AW-1:0] a;
      string tag;
      ld = ($urandom_range(0, 5) == 0);
      av = ($urandom_range(0, 2) != 0);
      md = 1'($urandom);
      a  = AW'($urandom);
      if (ld && av) tag = "R6";
      else if (ld) tag = "R2";
      else if (!av) tag = "R5";
      else if (m_ilv) tag = "R4";
      else tag = "R3";
      step(ld, av, md, a, tag);
    end

    // R1 reset in mid burst.
    @(negedge clk); rst_n = 1'b0;
    #1;
    check("R1", addr_o, '0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule